// File: doc/BRIEF.md
# Serial Controller Control-Port Write Sequencer

This block sits behind the control address of a programmable serial controller. The CPU side gives it a write strobe, a select that tells control writes from data writes, and an 8-bit data bus. The block decides what each control write means from where the write falls in a sequence that starts at reset. The first control write is the mode word. If that mode word picks synchronous operation, the next control write is a sync character, and it may be followed by a second one. Every later control write is a command.

The block keeps the mode word and the sync characters for the transmitter and the receiver. From the command word it drives level outputs: transmit enable, receive enable, the two handshake outputs and a forced break. It also drives one-cycle strobes for error clearing, hunt entry and soft reset. A command can restart the sequence, so that the next control write is taken as a new mode word. Writes to the data address pass by and do not move the sequence.

Top module: `usart_ctl_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, every register output and every strobe is 0, and the first control write (`wr_en`=1, `sel_ctl`=1) is stored in `mode_word`.
- R2: A mode write updates `mode_word` in the cycle after the write edge. The rate field is bits 1:0, where 0 means synchronous, 1 means divide-by-1, 2 means divide-by-16 and 3 means divide-by-64. The length field is bits 3:2, and `char_bits` shows 5, 6, 7 or 8 for field values 0 to 3. `is_sync` is 1 exactly when the stored rate field is 0.
- R3: When the mode word has rate field 0 and bit 7 at 0 (double sync), the next two control writes go to `sync1` and then `sync2`. After that, control writes are commands.
- R4: When the mode word has rate field 0 and bit 7 at 1 (single sync), only the next control write goes to `sync1`. Commands start on the write after it, and `sync2` is left unchanged.
- R5: When the mode word has a rate field other than 0, the next control write is a command. `sync1` and `sync2` are left unchanged.
- R6: A command with bit 6 at 0 sets the held levels from its own bits: `tx_en` from bit 0, `dtr` from bit 1, `rx_en` from bit 2, `brk` from bit 3 and `rts` from bit 5. Each level holds until the next such command.
- R7: A command with bit 4 at 1 and bit 6 at 0 raises `err_clr` for exactly the one cycle after the write edge. Nothing of that bit is kept.
- R8: A command with bit 7 at 1 and bit 6 at 0 raises `hunt` for the one cycle after the write edge, but only when `is_sync` is 1. In an asynchronous mode the bit has no effect.
- R9: A command with bit 6 at 1 raises `soft_rst` for one cycle. It clears `tx_en`, `rx_en`, `dtr`, `rts` and `brk`, and it ignores every other bit of that word, so no `err_clr` or `hunt` strobe is produced. The next control write is taken as a mode word. `mode_word`, `sync1` and `sync2` keep their values until they are rewritten.
- R10: A write with `sel_ctl`=0 changes no output and does not advance the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, asynchronous, active low |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| sel_ctl | input | 1 | 1 selects the control address, 0 the data address |
| wdata | input | 8 | Write data bus |
| mode_word | output | 8 | Stored mode word |
| char_bits | output | 4 | Character length in bits (5 to 8) |
| is_sync | output | 1 | Stored mode selects synchronous operation |
| sync1 | output | 8 | First sync character |
| sync2 | output | 8 | Second sync character |
| tx_en | output | 1 | Transmit enable level |
| rx_en | output | 1 | Receive enable level |
| dtr | output | 1 | Terminal-ready handshake output |
| rts | output | 1 | Request-to-send handshake output |
| brk | output | 1 | Force the line to break |
| err_clr | output | 1 | One-cycle error-flag clear strobe |
| hunt | output | 1 | One-cycle enter-hunt strobe |
| soft_rst | output | 1 | One-cycle internal-reset strobe |

## Verification
Every result is registered exactly once. The stored words, the command levels and the three strobes all change in the single cycle that follows the clock edge on which `wr_en` is sampled high, and each strobe drops again one cycle later unless another write follows. The bench drives a write on a falling edge and waits for the next rising edge. It then compares every output with its reference model on the following falling edge, which is the cycle where the result is due. Idle cycles are compared the same way, so that a strobe lasting longer than one cycle is caught. Back-to-back writes need no extra spacing, because each write's outputs are compared before the next rising edge.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

   // Sequence position: what the next control write means
   typedef enum logic [1:0] {
      PH_MODE  = 2'd0,
      PH_SYNC1 = 2'd1,
      PH_SYNC2 = 2'd2,
      PH_CMD   = 2'd3
   } ucs_phase_e;

   // Mode word field positions
   localparam int MODE_RATE_LO = 0;
   localparam int MODE_LEN_LO  = 2;
   localparam int MODE_SINGLE  = 7;
   localparam logic [1:0] RATE_SYNC = 2'd0;

   // Command word bit positions
   localparam int CMD_TXEN = 0;
   localparam int CMD_DTR  = 1;
   localparam int CMD_RXEN = 2;
   localparam int CMD_BRK  = 3;
   localparam int CMD_ECLR = 4;
   localparam int CMD_RTS  = 5;
   localparam int CMD_IRST = 6;
   localparam int CMD_HUNT = 7;

   localparam int MIN_CHAR_BITS = 5;

   typedef struct packed {
      logic tx_en;
      logic rx_en;
      logic dtr;
      logic rts;
      logic brk;
   } ucs_levels_t;

   function automatic logic [3:0] len_to_bits(input logic [1:0] fld);
      return 4'(MIN_CHAR_BITS) + {2'b00, fld};
   endfunction

endpackage

// File: rtl/ucs_sequencer.sv
module ucs_sequencer
   import ucs_pkg::*;
#(
   parameter int  DW       = 8,
   parameter bit  HAS_SYNC = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_wr,
   input  logic [DW-1:0] wdata,
   input  logic          single_sync,
   output logic          we_mode,
   output logic          we_sync1,
   output logic          we_sync2,
   output logic          we_cmd
);

   ucs_phase_e phase_q, phase_d, after_mode, after_sync1;

   // Pick where a mode write leads, by variant
   generate
      if (HAS_SYNC) begin : g_sync
         always_comb begin
            after_mode  = (wdata[MODE_RATE_LO +: 2] == RATE_SYNC) ? PH_SYNC1 : PH_CMD;
            after_sync1 = single_sync ? PH_CMD : PH_SYNC2;
         end
      end else begin : g_async_only
         always_comb begin
            after_mode  = PH_CMD;
            after_sync1 = PH_CMD;
         end
      end
   endgenerate

   always_comb begin
      we_mode  = ctl_wr && (phase_q == PH_MODE);
      we_sync1 = ctl_wr && (phase_q == PH_SYNC1);
      we_sync2 = ctl_wr && (phase_q == PH_SYNC2);
      we_cmd   = ctl_wr && (phase_q == PH_CMD);
   end

   always_comb begin
      phase_d = phase_q;
      if (ctl_wr) begin
         unique case (phase_q)
            PH_MODE:  phase_d = after_mode;
            PH_SYNC1: phase_d = after_sync1;
            PH_SYNC2: phase_d = PH_CMD;
            PH_CMD:   phase_d = wdata[CMD_IRST] ? PH_MODE : PH_CMD;
            default:  phase_d = PH_MODE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_MODE;
      else        phase_q <= phase_d;
   end

endmodule

// File: rtl/ucs_mode_regs.sv
module ucs_mode_regs
   import ucs_pkg::*;
#(
   parameter int DW       = 8,
   parameter bit HAS_SYNC = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_mode,
   input  logic          we_sync1,
   input  logic          we_sync2,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] mode_q,
   output logic [DW-1:0] sync1_q,
   output logic [DW-1:0] sync2_q,
   output logic          sync_mode,
   output logic          single_sync
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (we_mode) mode_q <= wdata;
   end

   generate
      if (HAS_SYNC) begin : g_sync_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync1_q <= '0;
               sync2_q <= '0;
            end else begin
               if (we_sync1) sync1_q <= wdata;
               if (we_sync2) sync2_q <= wdata;
            end
         end
         assign sync_mode = (mode_q[MODE_RATE_LO +: 2] == RATE_SYNC);
      end else begin : g_no_sync_store
         assign sync1_q   = '0;
         assign sync2_q   = '0;
         assign sync_mode = 1'b0;
      end
   endgenerate

   // Selects the next phase during a write to sync character 1
   assign single_sync = mode_q[MODE_SINGLE];

endmodule

// File: rtl/ucs_cmd_unit.sv
module ucs_cmd_unit
   import ucs_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_cmd,
   input  logic [DW-1:0] wdata,
   input  logic          sync_mode,
   output ucs_levels_t   lvl_q,
   output logic          err_clr_q,
   output logic          hunt_q,
   output logic          soft_rst_q
);

   logic irst;
   assign irst = wdata[CMD_IRST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q      <= '0;
         err_clr_q  <= 1'b0;
         hunt_q     <= 1'b0;
         soft_rst_q <= 1'b0;
      end else begin
         err_clr_q  <= we_cmd && !irst && wdata[CMD_ECLR];
         hunt_q     <= we_cmd && !irst && wdata[CMD_HUNT] && sync_mode;
         soft_rst_q <= we_cmd && irst;
         if (we_cmd) begin
            if (irst) begin
               lvl_q <= '0;
            end else begin
               lvl_q.tx_en <= wdata[CMD_TXEN];
               lvl_q.rx_en <= wdata[CMD_RXEN];
               lvl_q.dtr   <= wdata[CMD_DTR];
               lvl_q.rts   <= wdata[CMD_RTS];
               lvl_q.brk   <= wdata[CMD_BRK];
            end
         end
      end
   end

endmodule

// File: rtl/usart_ctl_seq.sv
module usart_ctl_seq
   import ucs_pkg::*;
#(
   parameter int DW       = 8,
   parameter bit HAS_SYNC = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          sel_ctl,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] mode_word,
   output logic [3:0]    char_bits,
   output logic          is_sync,
   output logic [DW-1:0] sync1,
   output logic [DW-1:0] sync2,
   output logic          tx_en,
   output logic          rx_en,
   output logic          dtr,
   output logic          rts,
   output logic          brk,
   output logic          err_clr,
   output logic          hunt,
   output logic          soft_rst
);

   localparam int CMD_MSB = CMD_HUNT;

   generate
      if (DW <= CMD_MSB) begin : g_bad_width
         $error("usart_ctl_seq: DW must cover command bit %0d", CMD_MSB);
      end
   endgenerate

   logic        ctl_wr;
   logic        we_mode, we_sync1, we_sync2, we_cmd;
   logic        single_sync, sync_mode;
   ucs_levels_t lvl;

   assign ctl_wr = wr_en && sel_ctl;

   ucs_sequencer #(.DW(DW), .HAS_SYNC(HAS_SYNC)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (ctl_wr),
      .wdata      (wdata),
      .single_sync(single_sync),
      .we_mode    (we_mode),
      .we_sync1   (we_sync1),
      .we_sync2   (we_sync2),
      .we_cmd     (we_cmd)
   );

   ucs_mode_regs #(.DW(DW), .HAS_SYNC(HAS_SYNC)) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_mode    (we_mode),
      .we_sync1   (we_sync1),
      .we_sync2   (we_sync2),
      .wdata      (wdata),
      .mode_q     (mode_word),
      .sync1_q    (sync1),
      .sync2_q    (sync2),
      .sync_mode  (sync_mode),
      .single_sync(single_sync)
   );

   ucs_cmd_unit #(.DW(DW)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_cmd    (we_cmd),
      .wdata     (wdata),
      .sync_mode (sync_mode),
      .lvl_q     (lvl),
      .err_clr_q (err_clr),
      .hunt_q    (hunt),
      .soft_rst_q(soft_rst)
   );

   assign char_bits = len_to_bits(mode_word[MODE_LEN_LO +: 2]);
   assign is_sync   = sync_mode;
   assign tx_en     = lvl.tx_en;
   assign rx_en     = lvl.rx_en;
   assign dtr       = lvl.dtr;
   assign rts       = lvl.rts;
   assign brk       = lvl.brk;

endmodule

// File: rtl/ucs_checker.sv
module ucs_checker #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          sel_ctl,
   input logic [DW-1:0] wdata,
   input logic [DW-1:0] mode_word,
   input logic [DW-1:0] sync1,
   input logic [DW-1:0] sync2,
   input logic          is_sync,
   input logic          tx_en,
   input logic          rx_en,
   input logic          dtr,
   input logic          rts,
   input logic          brk,
   input logic          err_clr,
   input logic          hunt,
   input logic          soft_rst
);

   // R9
   soft_rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> !(tx_en || rx_en || dtr || rts || brk || err_clr || hunt));

   // R10
   data_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sel_ctl) |=> ($stable(mode_word) && $stable(sync1) && $stable(sync2)
                               && $stable({tx_en, rx_en, dtr, rts, brk})
                               && !err_clr && !hunt && !soft_rst));

   // R8
   hunt_sync_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hunt |-> is_sync);

   // R7
   err_clr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_clr) |-> $past(wr_en && sel_ctl && wdata[4] && !wdata[6]));

   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_clr, soft_rst}) && $onehot0({hunt, soft_rst}));

   // R9
   soft_rst_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> $stable(mode_word) && $stable(sync1) && $stable(sync2));

endmodule

bind usart_ctl_seq ucs_checker #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .sel_ctl  (sel_ctl),
   .wdata    (wdata),
   .mode_word(mode_word),
   .sync1    (sync1),
   .sync2    (sync2),
   .is_sync  (is_sync),
   .tx_en    (tx_en),
   .rx_en    (rx_en),
   .dtr      (dtr),
   .rts      (rts),
   .brk      (brk),
   .err_clr  (err_clr),
   .hunt     (hunt),
   .soft_rst (soft_rst)
);

// File: tb/sim_usart_ctl_seq.sv
module sim_usart_ctl_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       sel_ctl = 1'b0;
   logic [7:0] wdata = 8'h00;

   logic [7:0] mode_word, sync1, sync2;
   logic [3:0] char_bits;
   logic       is_sync, tx_en, rx_en, dtr, rts, brk, err_clr, hunt, soft_rst;

   int n_cmp = 0;
   int n_bad = 0;

   // Reference model state
   int         m_ph;
   logic [7:0] m_mode, m_s1, m_s2;
   logic       m_tx, m_rx, m_dtr, m_rts, m_brk, m_ec, m_hu, m_sr;

   always #10 clk = ~clk;

   usart_ctl_seq u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel_ctl(sel_ctl), .wdata(wdata),
      .mode_word(mode_word), .char_bits(char_bits), .is_sync(is_sync),
      .sync1(sync1), .sync2(sync2), .tx_en(tx_en), .rx_en(rx_en), .dtr(dtr),
      .rts(rts), .brk(brk), .err_clr(err_clr), .hunt(hunt), .soft_rst(soft_rst)
   );

   function automatic logic [3:0] exp_bits(input logic [7:0] m);
      return 4'd5 + {2'b00, m[3:2]};
   endfunction

   task automatic cmp(input string req, input string what, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic model_reset();
      m_ph = 0; m_mode = '0; m_s1 = '0; m_s2 = '0;
      {m_tx, m_rx, m_dtr, m_rts, m_brk, m_ec, m_hu, m_sr} = '0;
   endtask

   // Apply one write to the model (bench reading of the requirements)
   task automatic model_write(input logic ctl, input logic [7:0] d);
      m_ec = 0; m_hu = 0; m_sr = 0;
      if (!ctl) return;                                   // R10
      case (m_ph)
         0: begin m_mode = d; m_ph = (d[1:0] == 2'd0) ? 1 : 3; end   // R2 R5
         1: begin m_s1 = d; m_ph = m_mode[7] ? 3 : 2; end            // R3 R4
         2: begin m_s2 = d; m_ph = 3; end                            // R3
         default: begin
            if (d[6]) begin                                          // R9
               {m_tx, m_rx, m_dtr, m_rts, m_brk} = '0;
               m_sr = 1; m_ph = 0;
            end else begin                                           // R6 R7 R8
               m_tx = d[0]; m_dtr = d[1]; m_rx = d[2]; m_brk = d[3]; m_rts = d[5];
               m_ec = d[4]; m_hu = d[7] && (m_mode[1:0] == 2'd0);
            end
         end
      endcase
   endtask

   task automatic check_all(input string req);
      cmp(req, "mode_word", mode_word, m_mode);
      cmp(req, "char_bits", char_bits, exp_bits(m_mode));
      cmp(req, "is_sync",   is_sync, (m_mode[1:0] == 2'd0));
      cmp(req, "sync1",     sync1, m_s1);
      cmp(req, "sync2",     sync2, m_s2);
      cmp(req, "tx_en",     tx_en, m_tx);
      cmp(req, "rx_en",     rx_en, m_rx);
      cmp(req, "dtr",       dtr, m_dtr);
      cmp(req, "rts",       rts, m_rts);
      cmp(req, "brk",       brk, m_brk);
      cmp(req, "err_clr",   err_clr, m_ec);
      cmp(req, "hunt",      hunt, m_hu);
      cmp(req, "soft_rst",  soft_rst, m_sr);
   endtask

   // Called on a falling edge; returns on the falling edge after the write's result is due
   task automatic wr(input logic ctl, input logic [7:0] d, input string req);
      wr_en = 1; sel_ctl = ctl; wdata = d;
      @(posedge clk);
      model_write(ctl, d);
      @(negedge clk);
      wr_en = 0;
      check_all(req);
   endtask

   task automatic idle(input string req);
      wr_en = 0;
      @(posedge clk);
      m_ec = 0; m_hu = 0; m_sr = 0;
      @(negedge clk);
      check_all(req);
   endtask

   task automatic do_reset();
      rst_n = 0; wr_en = 0;
      model_reset();
      @(negedge clk);
      check_all("R1");
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check_all("R1");
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5eed_1234);
      model_reset();
      @(negedge clk);
      do_reset();

      // R5 async mode, data writes ignored, then commands
      wr(0, 8'hFF, "R10");
      wr(1, 8'h4E, "R2");                 // rate 2, 8-bit chars
      wr(0, 8'h40, "R10");
      wr(1, 8'h27, "R6");                 // tx, dtr, rx, rts
      wr(1, 8'h10, "R7");                 // err clear pulse, levels drop
      idle("R7");
      wr(1, 8'h80, "R8");                 // hunt in async: no pulse
      wr(1, 8'h08, "R6");                 // break
      wr(1, 8'h7F, "R9");                 // internal reset ignores other bits
      idle("R9");

      // R3 double sync
      wr(1, 8'h0C, "R2");                 // sync, 8-bit
      wr(0, 8'hAA, "R10");
      wr(1, 8'h16, "R3");
      wr(0, 8'h55, "R10");
      wr(1, 8'h96, "R3");
      wr(1, 8'h85, "R8");                 // hunt pulse in sync mode
      wr(1, 8'h95, "R8");                 // back-to-back hunt and err clear
      idle("R8");
      wr(1, 8'h40, "R9");

      // R4 single sync
      wr(1, 8'h80, "R4");                 // sync, single, 5-bit
      wr(1, 8'h3C, "R4");
      wr(1, 8'h02, "R4");                 // this is a command, sync2 unchanged
      wr(1, 8'hC1, "R9");

      // R5 sync chars untouched by async mode
      wr(1, 8'hF7, "R5");
      wr(1, 8'h21, "R5");

      // R1 external reset mid-sequence
      wr(1, 8'h40, "R9");
      wr(1, 8'h00, "R3");
      do_reset();
      wr(1, 8'h0D, "R1");                 // first control write is a mode word

      // Constrained random phase
      for (int i = 0; i < 1500; i++) begin
         logic [7:0] d;
         logic       c;
         int         r;
         d = 8'($urandom);
         r = int'($urandom % 16);
         c = (r != 0);
         if (m_ph == 3 && r > 2) d[6] = 1'b0;   // keep soft resets occasional
         if (r == 15) idle("R7");
         else wr(c, d, "R6");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule